// File: doc/BRIEF.md
# General-Purpose Pin Bank with Edge Capture

This block controls a bank of up to 32 general-purpose pins through a small synchronous register bus. Each pin can be an input or an output. Software sets and clears output levels with two write-one registers, so one pin can change without a read-modify-write that might disturb another. The present level of every pin can be read whatever its direction. A parameter mask reverses the meaning of the direction bit on chosen pins.

Pin inputs are synchronized, then compared with their value one clock earlier. Enabled rising or falling transitions set sticky status bits. Software clears those bits by writing ones to them. The OR of all status bits drives a single interrupt line. The implemented pin count is a parameter. Bits above it are inert.

Top module: `gpio_edge_bank`

Word addresses: 0 level (read only), 1 direction, 2 set (write only), 3 clear (write only), 4 rising enable, 5 falling enable, 6 edge status. Address 7 is unused.

## Requirements
- R1: Bits at or above PIN_COUNT always read 0 in every register. Writes to those bits are ignored, those bits never drive pinOut or pinOe, and a transition on such a pin never sets status.
- R2: A read of address 0 returns the pin inputs after a two-flop synchronizer, whatever the pin directions. A pin change made before clock edge k is visible after edge k+1 and not after edge k.
- R3: A write to address 2 drives pinOut high on every implemented pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R4: A write to address 3 drives pinOut low on every implemented pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R5: Direction bit 1 means output, so pinOe is 1, unless the pin is set in DIR_INVERT. On those pins the meaning is reversed. After reset every pin is an input, and address 1 reads back DIR_INVERT masked to the implemented pins.
- R6: A change of direction never alters pinOut. The output value written while a pin is an input is the value it drives once it is switched to output.
- R7: Address 4 enables rising edges and address 5 enables falling edges, one bit per pin. If both are enabled, either transition sets status. A transition that is not enabled sets nothing.
- R8: Edge-status bits at address 6 stay set until a write to address 6 with a 1 in that bit. Zero bits in the write leave status unchanged, and writing all ones clears every bit.
- R9: If an enabled edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: irqOut is 1 exactly when at least one status bit is set, and it stays 1 until a clearing write.
- R11: Reads of addresses 2, 3 and 7 return 0. The read data is combinational on busAddr.
- R12: An enabled edge on a pin sets its status bit on the third rising clock edge after the pin input changes, counting the edge of the change as the first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Register word address |
| busWe | input | 1 | Write enable |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| pinIn | input | 32 | Pin input levels, asynchronous |
| pinOut | output | 32 | Output data per pin |
| pinOe | output | 32 | Output enable per pin |
| irqOut | output | 1 | Combined edge interrupt |

## Verification
The bench builds the bank with PIN_COUNT set to 24 and DIR_INVERT set to 32'h3. The reduced count lets the bench drive bits 24 to 31 and show that they are inert. The inversion mask makes the reset direction readback and the reversed output enable on pins 0 and 1 visible. The timing of edges is set against writes, so a status clear and a new edge fall on the same clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int BANK_W = 32;

  typedef enum logic [2:0] {
    REG_LEVEL = 3'd0,
    REG_DIR   = 3'd1,
    REG_SET   = 3'd2,
    REG_CLR   = 3'd3,
    REG_RISE  = 3'd4,
    REG_FALL  = 3'd5,
    REG_STAT  = 3'd6,
    REG_NONE  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrDir;
    logic    wrSet;
    logic    wrClr;
    logic    wrRise;
    logic    wrFall;
    logic    wrStat;
    regSel_e rdSel;
  } bankStrobe_t;
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
(
  input  logic [2:0]  busAddr,
  input  logic        busWe,
  output bankStrobe_t strobe
);
  always_comb begin
    strobe        = '0;
    strobe.rdSel  = regSel_e'(busAddr);
    if (busWe) begin
      unique case (regSel_e'(busAddr))
        REG_DIR:  strobe.wrDir  = 1'b1;
        REG_SET:  strobe.wrSet  = 1'b1;
        REG_CLR:  strobe.wrClr  = 1'b1;
        REG_RISE: strobe.wrRise = 1'b1;
        REG_FALL: strobe.wrFall = 1'b1;
        REG_STAT: strobe.wrStat = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int               PIN_COUNT  = 32,
  parameter logic [BANK_W-1:0] DIR_INVERT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strobe,
  input  logic [BANK_W-1:0] busWdata,
  output logic [BANK_W-1:0] busRdata,
  input  logic [BANK_W-1:0] pinIn,
  output logic [BANK_W-1:0] pinOut,
  output logic [BANK_W-1:0] pinOe,
  output logic [BANK_W-1:0] edgeStatus
);
  localparam logic [BANK_W-1:0] IMPL_MASK =
    (PIN_COUNT >= BANK_W) ? {BANK_W{1'b1}} : BANK_W'((64'd1 << PIN_COUNT) - 64'd1);
  localparam logic [BANK_W-1:0] DIR_RESET = DIR_INVERT & IMPL_MASK;

  logic [BANK_W-1:0] syncA, syncB, levelPrev;
  logic [BANK_W-1:0] dirReg, outReg, riseEn, fallEn, statReg;
  logic [BANK_W-1:0] hitVec, wMask, clrMask;

  assign wMask   = busWdata & IMPL_MASK;
  assign clrMask = strobe.wrStat ? wMask : '0;

  // two-flop synchronizer plus one history stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA     <= '0;
      syncB     <= '0;
      levelPrev <= '0;
    end else begin
      syncA     <= pinIn & IMPL_MASK;
      syncB     <= syncA;
      levelPrev <= syncB;
    end
  end

  // per-pin edge classification; unimplemented pins are tied off
  for (genvar p = 0; p < BANK_W; p++) begin : gPin
    if (p < PIN_COUNT) begin : gLive
      logic riseHit, fallHit;
      assign riseHit   = riseEn[p] & syncB[p] & ~levelPrev[p];
      assign fallHit   = fallEn[p] & ~syncB[p] & levelPrev[p];
      assign hitVec[p] = riseHit | fallHit;
    end else begin : gDead
      assign hitVec[p] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg  <= DIR_RESET;
      outReg  <= '0;
      riseEn  <= '0;
      fallEn  <= '0;
      statReg <= '0;
    end else begin
      if (strobe.wrDir)  dirReg <= wMask;
      if (strobe.wrRise) riseEn <= wMask;
      if (strobe.wrFall) fallEn <= wMask;
      if (strobe.wrSet)  outReg <= outReg | wMask;
      else if (strobe.wrClr) outReg <= outReg & ~wMask;
      // a fresh edge outranks a simultaneous clear
      statReg <= (statReg & ~clrMask) | hitVec;
    end
  end

  assign pinOut     = outReg;
  assign pinOe      = (dirReg ^ DIR_INVERT) & IMPL_MASK;
  assign edgeStatus = statReg;

  always_comb begin
    unique case (strobe.rdSel)
      REG_LEVEL: busRdata = syncB;
      REG_DIR:   busRdata = dirReg;
      REG_RISE:  busRdata = riseEn;
      REG_FALL:  busRdata = fallEn;
      REG_STAT:  busRdata = statReg;
      default:   busRdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_bank_pkg::*;
#(
  parameter int           PIN_COUNT  = 32,
  parameter logic [31:0]  DIR_INVERT = 32'h0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  busAddr,
  input  logic        busWe,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  input  logic [31:0] pinIn,
  output logic [31:0] pinOut,
  output logic [31:0] pinOe,
  output logic        irqOut
);
  bankStrobe_t strobe;
  logic [BANK_W-1:0] edgeStatus;

  gpio_bank_ctrl uCtrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobe  (strobe)
  );

  gpio_bank_dp #(
    .PIN_COUNT  (PIN_COUNT),
    .DIR_INVERT (DIR_INVERT)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .pinIn      (pinIn),
    .pinOut     (pinOut),
    .pinOe      (pinOe),
    .edgeStatus (edgeStatus)
  );

  assign irqOut = |edgeStatus;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int PIN_COUNT = 32
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  busAddr,
  input logic        busWe,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic [31:0] pinOut,
  input logic [31:0] pinOe,
  input logic        irqOut,
  input logic [31:0] edgeStatus
);
  localparam logic [31:0] IMPL_MASK =
    (PIN_COUNT >= 32) ? 32'hFFFF_FFFF : 32'((64'd1 << PIN_COUNT) - 64'd1);

  logic [31:0] clrPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clrPrev <= '0;
    else       clrPrev <= (busWe && busAddr == 3'd6) ? busWdata : '0;
  end

  // R1
  unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOut | pinOe | busRdata | edgeStatus) & ~IMPL_MASK) == 32'h0);

  // R3
  set_drives_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 3'd2) |=>
      ((pinOut & $past(busWdata & IMPL_MASK)) == $past(busWdata & IMPL_MASK)));

  // R4
  clr_drives_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == 3'd3) |=> ((pinOut & $past(busWdata)) == 32'h0));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeStatus) & ~clrPrev & ~edgeStatus) == 32'h0));

  // R10
  irq_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !(busWe && busAddr == 3'd6)) |=> irqOut);

  // R11
  wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 3'd2 || busAddr == 3'd3 || busAddr == 3'd7) |-> busRdata == 32'h0);
endmodule

bind gpio_edge_bank gpio_bank_chk #(.PIN_COUNT(PIN_COUNT)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .pinOut     (pinOut),
  .pinOe      (pinOe),
  .irqOut     (irqOut),
  .edgeStatus (edgeStatus)
);

// File: tb/sim_gpio_edge_bank.sv
module sim_gpio_edge_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe;
  logic        irqOut;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_bank #(.PIN_COUNT(24), .DIR_INVERT(32'h3)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // {write, addr, data, expected pinOut, expected read data}
  localparam logic [99:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 32'hFFFF_00FF, 32'h00FF_00FF, 32'h0},          // R3 R1
    {1'b1, 3'd3, 32'h0000_00F0, 32'h00FF_000F, 32'h0},          // R4
    {1'b0, 3'd2, 32'h0,         32'h00FF_000F, 32'h0},          // R11
    {1'b0, 3'd3, 32'h0,         32'h00FF_000F, 32'h0},          // R11
    {1'b1, 3'd1, 32'hFFFF_FFFF, 32'h00FF_000F, 32'h0},          // R6
    {1'b0, 3'd1, 32'h0,         32'h00FF_000F, 32'h00FF_FFFF},  // R1
    {1'b1, 3'd4, 32'hFFFF_FFFF, 32'h00FF_000F, 32'h0},          // R7
    {1'b0, 3'd4, 32'h0,         32'h00FF_000F, 32'h00FF_FFFF},  // R7
    {1'b1, 3'd5, 32'h0000_FF00, 32'h00FF_000F, 32'h0},          // R7
    {1'b0, 3'd5, 32'h0,         32'h00FF_000F, 32'h0000_FF00},  // R7
    {1'b0, 3'd7, 32'h0,         32'h00FF_000F, 32'h0},          // R11
    {1'b0, 3'd6, 32'h0,         32'h00FF_000F, 32'h0}           // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busWe = 1'b0; busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic wait3;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state
    @(negedge clk);
    chk("R5 reset pinOe", pinOe, 32'h0);
    chk("R3 reset pinOut", pinOut, 32'h0);
    chk("R10 reset irq", {31'h0, irqOut}, 32'h0);
    rd(3'd1, r); chk("R5 reset dir readback", r, 32'h3);
    rd(3'd0, r); chk("R2 reset level", r, 32'h0);

    // R2 synchronizer latency
    @(negedge clk); pinIn = 32'hA5A5_A5A5;
    @(posedge clk);
    @(negedge clk); busAddr = 3'd0; #1 chk("R2 one edge not yet", busRdata, 32'h0);
    @(posedge clk);
    @(negedge clk); busAddr = 3'd0; #1 chk("R2 level after two edges R1", busRdata, 32'h00A5_A5A5);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][99]) begin
        wr(VEC[i][98:96], VEC[i][95:64]);
        chk($sformatf("R3 R4 R6 vector %0d pinOut", i), pinOut, VEC[i][63:32]);
      end else begin
        rd(VEC[i][98:96], r);
        chk($sformatf("R11 vector %0d read", i), r, VEC[i][31:0]);
        chk($sformatf("R6 vector %0d pinOut", i), pinOut, VEC[i][63:32]);
      end
    end

    // direction inversion
    chk("R5 pinOe with inversion", pinOe, 32'h00FF_FFFC);
    wr(3'd1, 32'h0);
    chk("R5 pinOe dir zero", pinOe, 32'h0000_0003);
    chk("R6 pinOut kept", pinOut, 32'h00FF_000F);

    // R7 rising edge on pin 4, checked at R12 timing
    @(negedge clk); pinIn[4] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = 3'd6; #1 chk("R12 not before third edge", busRdata, 32'h0);
    @(posedge clk);
    rd(3'd6, r); chk("R7 rising sets status", r, 32'h10);
    chk("R10 irq high", {31'h0, irqOut}, 32'h1);

    // R7 falling edge on pin 8
    @(negedge clk); pinIn[8] = 1'b0; wait3;
    rd(3'd6, r); chk("R7 falling sets status", r, 32'h110);

    // R7 falling on pin 21 not enabled
    @(negedge clk); pinIn[21] = 1'b0; wait3;
    rd(3'd6, r); chk("R7 disabled edge ignored", r, 32'h110);

    // R1 unimplemented pin toggles
    @(negedge clk); pinIn[28] = 1'b1; wait3;
    rd(3'd6, r); chk("R1 unimplemented edge ignored", r, 32'h110);
    rd(3'd0, r); chk("R1 level hides unimplemented", r, 32'h0085_A4B5);

    // R8 partial clear
    wr(3'd6, 32'h10);
    rd(3'd6, r); chk("R8 partial clear", r, 32'h100);
    chk("R10 irq still high", {31'h0, irqOut}, 32'h1);

    // R9 collision: rising on pin 8 meets clear of bit 8
    @(negedge clk); pinIn[8] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); busAddr = 3'd6; busWdata = 32'h100; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk); busWe = 1'b0;
    rd(3'd6, r); chk("R9 edge beats clear", r, 32'h100);

    // R8 clear all
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, r); chk("R8 clear all", r, 32'h0);
    chk("R10 irq low", {31'h0, irqOut}, 32'h0);

    // R7 both edges enabled on pin 4
    wr(3'd5, 32'h0000_FF10);
    @(negedge clk); pinIn[4] = 1'b0; wait3;
    rd(3'd6, r); chk("R7 both enabled falling", r, 32'h10);
    wr(3'd6, 32'hFFFF_FFFF);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule